// File: doc/BRIEF.md
# Pointer-Addressed Accumulator Engine

This block is a small accumulator execution unit. It does not address memory directly from its commands. Every operand and destination address comes from one of three address registers. The source-A, source-B and destination registers sit in the same address space as a data RAM, so the command stream can rewrite them with ordinary stores. Commands that post-increment a register let one command sequence walk a table in memory.

Commands arrive on a valid/ready port that carries a 3-bit operation code and an 8-bit immediate. Fetching and sequencing those commands is left to the surrounding logic. Each accepted command spends one cycle on its memory access and one cycle on write-back. The accumulator and the three address registers are brought out as observation outputs.

Stores aimed above the last register address (0x10002) are dropped. With the default reset values the destination register cannot be steered there: a store to 0x10002 reloads it with a value below 0x10000.

Top module: `ptr_accum_core`

## Requirements
- R1: After reset the accumulator reads 0x00, source-A and source-B read 0x00000, the destination register reads 0x10000, and cmdReady is high.
- R2: A command is taken on a clock edge where cmdValid and cmdReady are both high. cmdReady is low for exactly the following cycle, and the command's effect on the outputs is visible once cmdReady is high again.
- R3: Operation code 0 loads the command's immediate into the accumulator.
- R4: Code 1 loads the accumulator with the word at the address held in source-A, and code 2 does the same using source-B.
- R5: Code 3 adds the word at the source-A address to the accumulator, and code 4 adds the word at the source-B address. The sum wraps modulo 256.
- R6: Code 5 performs the code 3 addition and then adds one to source-A.
- R7: Code 6 writes the accumulator to the address in the destination register. Addresses 0x00000 to 0x0FFFF select the data RAM, whose 2^RAM_AW words are indexed by the low RAM_AW address bits.
- R8: Code 7 performs the code 6 store and then adds one to the destination register. The increment applies to the register's value after the store.
- R9: Source-A, source-B and the destination register are mapped at 0x10000, 0x10001 and 0x10002. A store to one of these addresses sets that register to {its old bits [8:0], accumulator}. A load from one of these addresses returns bits [7:0] of that register.
- R10: Address register increments wrap modulo 2^17, so 0x1FFFF becomes 0x00000.
- R11: A load from any address above 0x10002 returns 0x00.
- R12: While no command is taken, the accumulator and all three address registers keep their values, whatever is on cmdOp and cmdImm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Engine can take a command this cycle |
| cmdOp | input | 3 | Operation code (0..7, see R3 to R8) |
| cmdImm | input | 8 | Immediate value for code 0 |
| accOut | output | 8 | Accumulator value |
| ptrAOut | output | 17 | Source-A address register |
| ptrBOut | output | 17 | Source-B address register |
| tgtOut | output | 17 | Destination address register |

## Verification
On every cycle, the checker confirms several behaviours:
- the one-cycle busy window that follows each accepted command;
- that the accumulator and address registers hold while the engine is idle;
- the +1 step, with wrap, of source-A after code 5 and of the destination register after code 7;
- the accumulator value after an immediate load.

Four behaviours depend on memory contents and on the order of commands, so only the directed scenarios show them:
- the data returned by loads and adds;
- the shift-in rewriting of address registers by stores;
- the low-byte readback of a register;
- zero reads from unmapped space.

// File: rtl/ptr_core_pkg.sv
package ptr_core_pkg;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int KEEP_W = ADDR_W - DATA_W;

  localparam logic [ADDR_W-1:0] MAP_SRC_A = 17'h10000;
  localparam logic [ADDR_W-1:0] MAP_SRC_B = 17'h10001;
  localparam logic [ADDR_W-1:0] MAP_DEST  = 17'h10002;

  typedef enum logic [2:0] {
    OP_LDI      = 3'd0,
    OP_LDA      = 3'd1,
    OP_LDB      = 3'd2,
    OP_ADDA     = 3'd3,
    OP_ADDB     = 3'd4,
    OP_ADDA_INC = 3'd5,
    OP_STORE    = 3'd6,
    OP_STORE_INC= 3'd7
  } cmd_op_e;

  typedef struct packed {
    logic readB;
    logic doRead;
    logic doWrite;
    logic accImm;
    logic accLoad;
    logic accAdd;
    logic incA;
    logic incT;
  } dp_strobe_t;
endpackage

// File: rtl/ptr_core_ctrl.sv
module ptr_core_ctrl
  import ptr_core_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdImm,
  output logic              cmdReady,
  output logic [DATA_W-1:0] immQ,
  output dp_strobe_t        stb
);
  logic    busy;
  logic    accept;
  cmd_op_e opNow;
  cmd_op_e opQ;

  assign cmdReady = !busy;
  assign accept   = cmdValid && !busy;
  assign opNow    = cmd_op_e'(cmdOp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      opQ  <= OP_LDI;
      immQ <= '0;
    end else begin
      busy <= accept;
      if (accept) begin
        opQ  <= opNow;
        immQ <= cmdImm;
      end
    end
  end

  always_comb begin
    stb = '0;
    if (accept) begin
      unique case (opNow)
        OP_LDA, OP_ADDA, OP_ADDA_INC: stb.doRead = 1'b1;
        OP_LDB, OP_ADDB: begin
          stb.doRead = 1'b1;
          stb.readB  = 1'b1;
        end
        OP_STORE, OP_STORE_INC: stb.doWrite = 1'b1;
        default: ;
      endcase
    end
    if (busy) begin
      unique case (opQ)
        OP_LDI:          stb.accImm  = 1'b1;
        OP_LDA, OP_LDB:  stb.accLoad = 1'b1;
        OP_ADDA, OP_ADDB: stb.accAdd = 1'b1;
        OP_ADDA_INC: begin
          stb.accAdd = 1'b1;
          stb.incA   = 1'b1;
        end
        OP_STORE_INC:    stb.incT    = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptr_core_dp.sv
module ptr_core_dp
  import ptr_core_pkg::*;
#(
  parameter int RAM_AW = 10,
  parameter logic [ADDR_W-1:0] SRC_A_RST = 17'h00000,
  parameter logic [ADDR_W-1:0] SRC_B_RST = 17'h00000,
  parameter logic [ADDR_W-1:0] DEST_RST  = 17'h10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        stb,
  input  logic [DATA_W-1:0] immQ,
  output logic [DATA_W-1:0] accOut,
  output logic [ADDR_W-1:0] ptrAOut,
  output logic [ADDR_W-1:0] ptrBOut,
  output logic [ADDR_W-1:0] tgtOut
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] ram [RAM_DEPTH];
  logic [DATA_W-1:0] acc, rdData, rdWord;
  logic [ADDR_W-1:0] ptrA, ptrB, tgt, rdAddr;
  logic              wrRam, wrA, wrB, wrT;

  assign rdAddr = stb.readB ? ptrB : ptrA;
  assign wrRam  = stb.doWrite && !tgt[ADDR_W-1];
  assign wrA    = stb.doWrite && (tgt == MAP_SRC_A);
  assign wrB    = stb.doWrite && (tgt == MAP_SRC_B);
  assign wrT    = stb.doWrite && (tgt == MAP_DEST);

  always_comb begin
    if (!rdAddr[ADDR_W-1])        rdWord = ram[rdAddr[RAM_AW-1:0]];
    else if (rdAddr == MAP_SRC_A) rdWord = ptrA[DATA_W-1:0];
    else if (rdAddr == MAP_SRC_B) rdWord = ptrB[DATA_W-1:0];
    else if (rdAddr == MAP_DEST)  rdWord = tgt[DATA_W-1:0];
    else                          rdWord = '0;
  end

  always_ff @(posedge clk) begin
    if (wrRam) ram[tgt[RAM_AW-1:0]] <= acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      rdData <= '0;
      ptrA   <= SRC_A_RST;
      ptrB   <= SRC_B_RST;
      tgt    <= DEST_RST;
    end else begin
      if (stb.doRead) rdData <= rdWord;

      if (stb.accImm)       acc <= immQ;
      else if (stb.accLoad) acc <= rdData;
      else if (stb.accAdd)  acc <= acc + rdData;

      if (wrA)           ptrA <= {ptrA[KEEP_W-1:0], acc};
      else if (stb.incA) ptrA <= ptrA + ADDR_W'(1);

      if (wrB) ptrB <= {ptrB[KEEP_W-1:0], acc};

      if (wrT)           tgt <= {tgt[KEEP_W-1:0], acc};
      else if (stb.incT) tgt <= tgt + ADDR_W'(1);
    end
  end

  assign accOut  = acc;
  assign ptrAOut = ptrA;
  assign ptrBOut = ptrB;
  assign tgtOut  = tgt;
endmodule

// File: rtl/ptr_accum_core.sv
module ptr_accum_core
  import ptr_core_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [2:0]  cmdOp,
  input  logic [7:0]  cmdImm,
  output logic [7:0]  accOut,
  output logic [16:0] ptrAOut,
  output logic [16:0] ptrBOut,
  output logic [16:0] tgtOut
);
  dp_strobe_t        stb;
  logic [DATA_W-1:0] immQ;

  ptr_core_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdImm(cmdImm), .cmdReady(cmdReady), .immQ(immQ), .stb(stb)
  );

  ptr_core_dp #(.RAM_AW(RAM_AW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .immQ(immQ), .accOut(accOut),
    .ptrAOut(ptrAOut), .ptrBOut(ptrBOut), .tgtOut(tgtOut)
  );
endmodule

// File: rtl/ptr_accum_core_chk.sv
module ptr_accum_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [2:0]  cmdOp,
  input logic [7:0]  cmdImm,
  input logic [7:0]  accOut,
  input logic [16:0] ptrAOut,
  input logic [16:0] ptrBOut,
  input logic [16:0] tgtOut
);
  logic [2:0] opSeen;
  logic [7:0] immSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSeen  <= 3'd0;
      immSeen <= 8'd0;
    end else if (cmdValid && cmdReady) begin
      opSeen  <= cmdOp;
      immSeen <= cmdImm;
    end
  end

  assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  assert_ready_returns_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |=> cmdReady);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdValid) |=> ($stable(accOut) && $stable(ptrAOut)
                                 && $stable(ptrBOut) && $stable(tgtOut)));

  assert_imm_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && opSeen == 3'd0) |=> accOut == $past(immSeen));

  assert_src_a_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && opSeen == 3'd5) |=> ptrAOut == $past(ptrAOut) + 17'd1);

  assert_dest_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && opSeen == 3'd7) |=> tgtOut == $past(tgtOut) + 17'd1);
endmodule

bind ptr_accum_core ptr_accum_core_chk uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOp(cmdOp), .cmdImm(cmdImm), .accOut(accOut), .ptrAOut(ptrAOut),
  .ptrBOut(ptrBOut), .tgtOut(tgtOut)
);

// File: tb/sim_ptr_accum_core.sv
`timescale 1ns/1ps
module sim_ptr_accum_core;
  localparam logic [2:0] LDI = 3'd0, LDA = 3'd1, LDB = 3'd2, ADDA = 3'd3,
                         ADDB = 3'd4, ADDAI = 3'd5, STO = 3'd6, STOI = 3'd7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = 3'd0;
  logic [7:0]  cmdImm = 8'd0;
  logic [7:0]  accOut;
  logic [16:0] ptrAOut, ptrBOut, tgtOut;
  int          nTests = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  ptr_accum_core u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdImm(cmdImm), .accOut(accOut), .ptrAOut(ptrAOut),
    .ptrBOut(ptrBOut), .tgtOut(tgtOut)
  );

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cmdValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [7:0] imm);
    cmdValid = 1'b1;
    cmdOp = op;
    cmdImm = imm;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    check("R1 acc", {9'd0, accOut}, 17'h0);
    check("R1 srcA", ptrAOut, 17'h0);
    check("R1 srcB", ptrBOut, 17'h0);
    check("R1 dest", tgtOut, 17'h10000);
    check("R1 ready", {16'd0, cmdReady}, 17'h1);
  endtask

  task automatic tHandshake();
    doReset();
    cmdValid = 1'b1;
    cmdOp = LDI;
    cmdImm = 8'h5A;
    check("R2 ready before", {16'd0, cmdReady}, 17'h1);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R2 busy", {16'd0, cmdReady}, 17'h0);
    check("R2 not yet", {9'd0, accOut}, 17'h0);
    @(negedge clk);
    check("R2 ready again", {16'd0, cmdReady}, 17'h1);
    check("R3 imm load", {9'd0, accOut}, 17'h5A);
  endtask

  task automatic tIdleHold();
    for (int i = 0; i < 5; i++) begin
      cmdOp = 3'(i + 3);
      cmdImm = 8'(i * 37);
      @(negedge clk);
    end
    check("R12 acc", {9'd0, accOut}, 17'h5A);
    check("R12 srcA", ptrAOut, 17'h0);
    check("R12 dest", tgtOut, 17'h10000);
  endtask

  task automatic tMemOps();
    doReset();
    runCmd(LDI, 8'h02); runCmd(STO, 8'h00);
    runCmd(LDI, 8'h20); runCmd(STOI, 8'h00);
    check("R9 srcA shift", ptrAOut, 17'h00220);
    check("R8 dest inc", tgtOut, 17'h10001);
    runCmd(LDI, 8'h02); runCmd(STO, 8'h00);
    runCmd(LDI, 8'h21); runCmd(STOI, 8'h00);
    check("R9 srcB shift", ptrBOut, 17'h00221);
    runCmd(LDI, 8'h20); runCmd(STO, 8'h00);
    check("R9 dest rewrite", tgtOut, 17'h00220);
    runCmd(LDI, 8'h05); runCmd(STOI, 8'h00);
    check("R8 dest step", tgtOut, 17'h00221);
    runCmd(LDI, 8'h07); runCmd(STO, 8'h00);
    check("R7 dest held", tgtOut, 17'h00221);
    runCmd(LDA, 8'h00);
    check("R4 load A", {9'd0, accOut}, 17'h05);
    runCmd(ADDB, 8'h00);
    check("R5 add B", {9'd0, accOut}, 17'h0C);
    runCmd(LDB, 8'h00);
    check("R4 load B", {9'd0, accOut}, 17'h07);
    runCmd(ADDAI, 8'h00);
    check("R6 add A", {9'd0, accOut}, 17'h0C);
    check("R6 srcA inc", ptrAOut, 17'h00221);
    runCmd(ADDA, 8'h00);
    check("R5 add A", {9'd0, accOut}, 17'h13);
    runCmd(LDI, 8'hFE); runCmd(ADDB, 8'h00);
    check("R5 wrap", {9'd0, accOut}, 17'h05);
    runCmd(LDI, 8'h99); runCmd(STO, 8'h00);
    runCmd(LDI, 8'h00); runCmd(LDB, 8'h00);
    check("R7 store readback", {9'd0, accOut}, 17'h99);
  endtask

  task automatic tRegRead();
    doReset();
    runCmd(LDI, 8'h01); runCmd(STO, 8'h00);
    runCmd(LDI, 8'h00); runCmd(STO, 8'h00);
    runCmd(LDI, 8'h01); runCmd(STOI, 8'h00);
    check("R9 srcA full", ptrAOut, 17'h10001);
    runCmd(LDI, 8'h3C); runCmd(STO, 8'h00);
    runCmd(LDI, 8'h00); runCmd(LDA, 8'h00);
    check("R9 reg readback", {9'd0, accOut}, 17'h3C);
  endtask

  task automatic tUnmappedWrap();
    doReset();
    runCmd(LDI, 8'h01); runCmd(STO, 8'h00);
    runCmd(LDI, 8'hFF); runCmd(STO, 8'h00);
    runCmd(STO, 8'h00);
    check("R9 srcA top", ptrAOut, 17'h1FFFF);
    runCmd(LDI, 8'h44); runCmd(ADDAI, 8'h00);
    check("R11 zero read", {9'd0, accOut}, 17'h44);
    check("R10 wrap", ptrAOut, 17'h00000);
  endtask

  initial begin
    tReset();
    tHandshake();
    tIdleHold();
    tMemOps();
    tRegRead();
    tUnmappedWrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule